// File: doc/BRIEF.md
# Thread-Aware DRAM Request Picker

This block holds a small shared queue of DRAM requests posted by several hardware threads and, every cycle, names the one request that should go to the memory next. The choice is made by a single-cycle combinational arbiter over the queued entries. The granted entry leaves the queue on the clock edge where the consumer accepts it. Each queued entry carries its thread number, bank, row, a write flag and a waiting-time stamp.

The ordering is built in layers. At the top is a per-thread metric chosen at run time: either the number of requests that thread still has waiting in the queue (fewer is better), or an occupancy figure for core resources that the core supplies per thread (more is better). Below that come a hit on the open row of the request's bank, then reads before writes, then the longest-waiting request, and finally the lowest queue slot. The block keeps the open row of every bank itself. In open-page mode a granted access leaves its row open. In close-page mode every bank is closed after its access, so no request counts as a hit.

Top module: `dts_sched_top`

## Requirements
- R1: A request is accepted (`enq_valid` and `enq_ready` both high at a clock edge) whenever a free slot exists. `enq_ready` is low when all QDEPTH (default 8) slots are taken, and a request offered while `enq_ready` is low is dropped and never granted.
- R2: `gnt_valid` is high exactly when the queue holds at least one entry. An entry accepted at an edge can be granted only from the following cycle. An entry is removed at the edge where `gnt_valid` and `gnt_ready` are both high.
- R3: With `policy_mode` = 2'b01 (pending-count ordering), a request from a thread with fewer entries in the queue beats one from a thread with more, whatever the lower criteria say.
- R4: With `policy_mode` = 2'b10 (occupancy ordering), a request from a thread whose `occ_count` field is larger wins. Field t of `occ_count` is bits [t*OCC_W +: OCC_W]. The choice follows changes of `occ_count` in the same cycle.
- R5: With `policy_mode` = 2'b00 (or the unused code 2'b11), thread identity and thread metrics play no part in the choice.
- R6: When the thread criterion ties, a request whose row equals the open row of its bank beats a request that misses.
- R7: When the thread and row-hit criteria tie, a read (`enq_write` = 0) beats a write (`enq_write` = 1).
- R8: When all of the above tie, the request that has waited longer wins. On an exact tie, the lowest queue slot wins.
- R9: With `open_page_mode` = 1, a granted access leaves its row open in its own bank only. Other banks keep their own open rows.
- R10: With `open_page_mode` = 0, a granted access closes its bank, and no request is treated as a row hit.
- R11: A thread's pending count rises on each accepted request from it and falls on each grant of one of its requests. It is unchanged when both happen in one cycle, and it is bounded by QDEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_mode | input | 2 | 00 plain, 01 pending-count, 10 occupancy, 11 plain |
| open_page_mode | input | 1 | 1 keeps rows open after access, 0 closes them |
| occ_count | input | NTHREADS*OCC_W | Per-thread occupancy figures from the core |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Queue has a free slot |
| enq_thread | input | TID_W | Thread of the new request |
| enq_bank | input | BANK_W | Bank of the new request |
| enq_row | input | ROW_W | Row of the new request |
| enq_write | input | 1 | 1 = write, 0 = read |
| gnt_valid | output | 1 | A request is being presented |
| gnt_ready | input | 1 | Consumer accepts the presented request |
| gnt_thread | output | TID_W | Thread of the presented request |
| gnt_bank | output | BANK_W | Bank of the presented request |
| gnt_row | output | ROW_W | Row of the presented request |
| gnt_write | output | 1 | Write flag of the presented request |

## Verification
Every cycle, the assertions check four things. Grant validity tracks queue occupancy. The per-thread pending counts add up to the number of live entries. A grant in pending-count mode never passes over a thread with fewer waiting requests. The bank table opens or closes the granted bank as the page mode says. The layered orderings below the thread metric need queue contents built on purpose, and only the bench scenarios can show them: row hit over age, read over write, per-bank row tracking, the close-page loss of hits, the same-cycle accept-and-grant rule, and a counter decrement that changes which thread wins.

// File: rtl/dts_pkg.sv
package dts_pkg;

   typedef enum logic [1:0] {
      POL_PLAIN     = 2'b00,
      POL_PENDING   = 2'b01,
      POL_OCCUPANCY = 2'b10,
      POL_SPARE     = 2'b11
   } policy_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dts_req_queue.sv
module dts_req_queue #(
   parameter int QDEPTH = 8,
   parameter int TID_W  = 2,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 12,
   parameter int AGE_W  = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          enq_fire,
   input  logic [TID_W-1:0]              enq_tid,
   input  logic [BANK_W-1:0]             enq_bank,
   input  logic [ROW_W-1:0]              enq_row,
   input  logic                          enq_wr,
   input  logic                          deq_fire,
   input  logic [$clog2(QDEPTH)-1:0]     deq_slot,
   output logic [QDEPTH-1:0]             q_valid,
   output logic [QDEPTH-1:0][TID_W-1:0]  q_tid,
   output logic [QDEPTH-1:0][BANK_W-1:0] q_bank,
   output logic [QDEPTH-1:0][ROW_W-1:0]  q_row,
   output logic [QDEPTH-1:0]             q_wr,
   output logic [QDEPTH-1:0][AGE_W-1:0]  q_age,
   output logic                          full
);
   localparam int SLOT_W  = $clog2(QDEPTH);
   localparam int AGE_MAX = (1 << AGE_W) - 1;

   if (QDEPTH < 2) begin : g_bad_depth
      $error("dts_req_queue: QDEPTH must be at least 2");
   end
   if (AGE_W < 2) begin : g_bad_age
      $error("dts_req_queue: AGE_W must be at least 2");
   end

   logic [SLOT_W-1:0] free_slot;

   always_comb begin
      free_slot = '0;
      for (int i = QDEPTH - 1; i >= 0; i--) begin
         if (!q_valid[i]) free_slot = SLOT_W'(i);
      end
   end

   assign full = &q_valid;

   for (genvar s = 0; s < QDEPTH; s++) begin : g_slot
      logic take, drop;
      assign take = enq_fire && (free_slot == SLOT_W'(s));
      assign drop = deq_fire && (deq_slot == SLOT_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_valid[s] <= 1'b0;
            q_tid[s]   <= '0;
            q_bank[s]  <= '0;
            q_row[s]   <= '0;
            q_wr[s]    <= 1'b0;
            q_age[s]   <= '0;
         end else if (take) begin
            q_valid[s] <= 1'b1;
            q_tid[s]   <= enq_tid;
            q_bank[s]  <= enq_bank;
            q_row[s]   <= enq_row;
            q_wr[s]    <= enq_wr;
            q_age[s]   <= '0;
         end else if (drop) begin
            q_valid[s] <= 1'b0;
         end else if (q_valid[s] && (q_age[s] != AGE_W'(AGE_MAX))) begin
            q_age[s]   <= q_age[s] + 1'b1;
         end
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      full && !deq_fire |=> full);

endmodule

// File: rtl/dts_thread_track.sv
module dts_thread_track #(
   parameter int NTHREADS = 4,
   parameter int QDEPTH   = 8,
   parameter int TID_W    = 2,
   parameter int CNT_W    = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            enq_fire,
   input  logic [TID_W-1:0]                enq_tid,
   input  logic                            deq_fire,
   input  logic [TID_W-1:0]                deq_tid,
   output logic [NTHREADS-1:0][CNT_W-1:0]  pending
);
   if ((1 << CNT_W) <= QDEPTH) begin : g_bad_cnt
      $error("dts_thread_track: CNT_W too narrow for QDEPTH");
   end
   if ((1 << TID_W) < NTHREADS) begin : g_bad_tid
      $error("dts_thread_track: TID_W too narrow for NTHREADS");
   end

   for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
      logic inc, dec;
      assign inc = enq_fire && (enq_tid == TID_W'(t));
      assign dec = deq_fire && (deq_tid == TID_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pending[t] <= '0;
         end else begin
            case ({inc, dec})
               2'b10: if (pending[t] != CNT_W'(QDEPTH)) pending[t] <= pending[t] + 1'b1;
               2'b01: if (pending[t] != '0)             pending[t] <= pending[t] - 1'b1;
               default: pending[t] <= pending[t];
            endcase
         end
      end

      assert_pending_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
         pending[t] <= CNT_W'(QDEPTH));
   end

endmodule

// File: rtl/dts_bank_rows.sv
module dts_bank_rows #(
   parameter int NBANKS = 4,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          open_mode,
   input  logic                          upd_fire,
   input  logic [BANK_W-1:0]             upd_bank,
   input  logic [ROW_W-1:0]              upd_row,
   output logic [NBANKS-1:0]             row_open,
   output logic [NBANKS-1:0][ROW_W-1:0]  row_addr
);
   if ((1 << BANK_W) != NBANKS) begin : g_bad_banks
      $error("dts_bank_rows: NBANKS must equal 2**BANK_W");
   end

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic hit_me;
      assign hit_me = upd_fire && (upd_bank == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_open[b] <= 1'b0;
            row_addr[b] <= '0;
         end else if (hit_me) begin
            row_open[b] <= open_mode;
            row_addr[b] <= upd_row;
         end
      end
   end

   assert_open_row_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_fire && open_mode |=> row_open[$past(upd_bank)] && (row_addr[$past(upd_bank)] == $past(upd_row)));

   assert_close_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_fire && !open_mode |=> !row_open[$past(upd_bank)]);

endmodule

// File: rtl/dts_pick_arbiter.sv
module dts_pick_arbiter
   import dts_pkg::*;
#(
   parameter int QDEPTH      = 8,
   parameter int NTHREADS    = 4,
   parameter int NBANKS      = 4,
   parameter int TID_W       = 2,
   parameter int BANK_W      = 2,
   parameter int ROW_W       = 12,
   parameter int AGE_W       = 6,
   parameter int CNT_W       = 4,
   parameter int OCC_W       = 8,
   parameter bit THREAD_AWARE = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [1:0]                      policy_mode,
   input  logic                            open_mode,
   input  logic [NTHREADS*OCC_W-1:0]       occ_flat,
   input  logic [QDEPTH-1:0]               q_valid,
   input  logic [QDEPTH-1:0][TID_W-1:0]    q_tid,
   input  logic [QDEPTH-1:0][BANK_W-1:0]   q_bank,
   input  logic [QDEPTH-1:0][ROW_W-1:0]    q_row,
   input  logic [QDEPTH-1:0]               q_wr,
   input  logic [QDEPTH-1:0][AGE_W-1:0]    q_age,
   input  logic [NTHREADS-1:0][CNT_W-1:0]  pending,
   input  logic [NBANKS-1:0]               row_open,
   input  logic [NBANKS-1:0][ROW_W-1:0]    row_addr,
   output logic                            win_valid,
   output logic [$clog2(QDEPTH)-1:0]       win_slot
);
   localparam int SLOT_W  = $clog2(QDEPTH);
   localparam int SCORE_W = imax(OCC_W, CNT_W);
   localparam int KEY_W   = SCORE_W + 2 + AGE_W;

   logic [QDEPTH-1:0][SCORE_W-1:0] score;
   logic [QDEPTH-1:0]              hit;
   logic [QDEPTH-1:0][KEY_W-1:0]   key;

   if (THREAD_AWARE) begin : g_aware
      always_comb begin
         for (int i = 0; i < QDEPTH; i++) begin
            case (policy_e'(policy_mode))
               POL_PENDING:   score[i] = SCORE_W'(QDEPTH) - SCORE_W'(pending[q_tid[i]]);
               POL_OCCUPANCY: score[i] = SCORE_W'(occ_flat[q_tid[i]*OCC_W +: OCC_W]);
               default:       score[i] = '0;
            endcase
         end
      end
   end else begin : g_plain
      assign score = '0;
   end

   for (genvar i = 0; i < QDEPTH; i++) begin : g_key
      assign hit[i] = open_mode && row_open[q_bank[i]] && (row_addr[q_bank[i]] == q_row[i]);
      assign key[i] = {score[i], hit[i], ~q_wr[i], q_age[i]};
   end

   always_comb begin
      logic [KEY_W-1:0] best;
      best      = '0;
      win_valid = 1'b0;
      win_slot  = '0;
      for (int i = 0; i < QDEPTH; i++) begin
         if (q_valid[i] && (!win_valid || (key[i] > best))) begin
            win_valid = 1'b1;
            win_slot  = SLOT_W'(i);
            best      = key[i];
         end
      end
   end

   logic fewer_skipped;
   always_comb begin
      fewer_skipped = 1'b0;
      for (int j = 0; j < QDEPTH; j++) begin
         if (q_valid[j] && (pending[q_tid[j]] < pending[q_tid[win_slot]]))
            fewer_skipped = 1'b1;
      end
   end

   assert_fewest_pending_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (THREAD_AWARE && win_valid && (policy_mode == 2'b01)) |-> !fewer_skipped);

endmodule

// File: rtl/dts_sched_top.sv
module dts_sched_top #(
   parameter int NTHREADS     = 4,
   parameter int QDEPTH       = 8,
   parameter int NBANKS       = 4,
   parameter int ROW_W        = 12,
   parameter int AGE_W        = 6,
   parameter int OCC_W        = 8,
   parameter bit THREAD_AWARE = 1'b1,
   parameter int TID_W        = $clog2(NTHREADS),
   parameter int BANK_W       = $clog2(NBANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  policy_mode,
   input  logic                        open_page_mode,
   input  logic [NTHREADS*OCC_W-1:0]   occ_count,
   input  logic                        enq_valid,
   output logic                        enq_ready,
   input  logic [TID_W-1:0]            enq_thread,
   input  logic [BANK_W-1:0]           enq_bank,
   input  logic [ROW_W-1:0]            enq_row,
   input  logic                        enq_write,
   output logic                        gnt_valid,
   input  logic                        gnt_ready,
   output logic [TID_W-1:0]            gnt_thread,
   output logic [BANK_W-1:0]           gnt_bank,
   output logic [ROW_W-1:0]            gnt_row,
   output logic                        gnt_write
);
   localparam int SLOT_W = $clog2(QDEPTH);
   localparam int CNT_W  = $clog2(QDEPTH + 1);

   if (NTHREADS < 2) begin : g_bad_thr
      $error("dts_sched_top: NTHREADS must be at least 2");
   end
   if (ROW_W < 1 || OCC_W < 1) begin : g_bad_w
      $error("dts_sched_top: ROW_W and OCC_W must be positive");
   end

   logic [QDEPTH-1:0]              q_valid;
   logic [QDEPTH-1:0][TID_W-1:0]   q_tid;
   logic [QDEPTH-1:0][BANK_W-1:0]  q_bank;
   logic [QDEPTH-1:0][ROW_W-1:0]   q_row;
   logic [QDEPTH-1:0]              q_wr;
   logic [QDEPTH-1:0][AGE_W-1:0]   q_age;
   logic                           q_full;
   logic [NTHREADS-1:0][CNT_W-1:0] pending;
   logic [NBANKS-1:0]              row_open;
   logic [NBANKS-1:0][ROW_W-1:0]   row_addr;
   logic                           win_valid;
   logic [SLOT_W-1:0]              win_slot;
   logic                           enq_fire, gnt_fire;

   assign enq_ready = !q_full;
   assign enq_fire  = enq_valid && enq_ready;
   assign gnt_fire  = gnt_valid && gnt_ready;

   assign gnt_valid  = win_valid;
   assign gnt_thread = q_tid[win_slot];
   assign gnt_bank   = q_bank[win_slot];
   assign gnt_row    = q_row[win_slot];
   assign gnt_write  = q_wr[win_slot];

   dts_req_queue #(
      .QDEPTH(QDEPTH), .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n),
      .enq_fire(enq_fire), .enq_tid(enq_thread), .enq_bank(enq_bank),
      .enq_row(enq_row), .enq_wr(enq_write),
      .deq_fire(gnt_fire), .deq_slot(win_slot),
      .q_valid(q_valid), .q_tid(q_tid), .q_bank(q_bank), .q_row(q_row),
      .q_wr(q_wr), .q_age(q_age), .full(q_full)
   );

   dts_thread_track #(
      .NTHREADS(NTHREADS), .QDEPTH(QDEPTH), .TID_W(TID_W), .CNT_W(CNT_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n),
      .enq_fire(enq_fire), .enq_tid(enq_thread),
      .deq_fire(gnt_fire), .deq_tid(gnt_thread),
      .pending(pending)
   );

   dts_bank_rows #(
      .NBANKS(NBANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
   ) u_rows (
      .clk(clk), .rst_n(rst_n), .open_mode(open_page_mode),
      .upd_fire(gnt_fire), .upd_bank(gnt_bank), .upd_row(gnt_row),
      .row_open(row_open), .row_addr(row_addr)
   );

   dts_pick_arbiter #(
      .QDEPTH(QDEPTH), .NTHREADS(NTHREADS), .NBANKS(NBANKS), .TID_W(TID_W),
      .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W), .CNT_W(CNT_W),
      .OCC_W(OCC_W), .THREAD_AWARE(THREAD_AWARE)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .policy_mode(policy_mode), .open_mode(open_page_mode),
      .occ_flat(occ_count), .q_valid(q_valid), .q_tid(q_tid), .q_bank(q_bank),
      .q_row(q_row), .q_wr(q_wr), .q_age(q_age), .pending(pending),
      .row_open(row_open), .row_addr(row_addr),
      .win_valid(win_valid), .win_slot(win_slot)
   );

   int live_cnt, pend_sum;
   always_comb begin
      live_cnt = 0;
      pend_sum = 0;
      for (int i = 0; i < QDEPTH; i++)   live_cnt += int'(q_valid[i]);
      for (int t = 0; t < NTHREADS; t++) pend_sum += int'(pending[t]);
   end

   assert_pending_sum_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pend_sum == live_cnt);

   assert_grant_when_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid == (live_cnt != 0));

endmodule

// File: tb/dts_sched_top_bench.sv
module dts_sched_top_bench;
   localparam int NT = 4;
   localparam int OW = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       policy_mode = 2'b00;
   logic             open_page_mode = 1'b1;
   logic [NT*OW-1:0] occ_count = '0;
   logic             enq_valid = 1'b0;
   logic             enq_ready;
   logic [1:0]       enq_thread = '0;
   logic [1:0]       enq_bank = '0;
   logic [11:0]      enq_row = '0;
   logic             enq_write = 1'b0;
   logic             gnt_valid;
   logic             gnt_ready = 1'b0;
   logic [1:0]       gnt_thread;
   logic [1:0]       gnt_bank;
   logic [11:0]      gnt_row;
   logic             gnt_write;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   dts_sched_top u_dts_sched_top (
      .clk(clk), .rst_n(rst_n), .policy_mode(policy_mode),
      .open_page_mode(open_page_mode), .occ_count(occ_count),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_thread(enq_thread),
      .enq_bank(enq_bank), .enq_row(enq_row), .enq_write(enq_write),
      .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_thread(gnt_thread),
      .gnt_bank(gnt_bank), .gnt_row(gnt_row), .gnt_write(gnt_write)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; enq_valid = 1'b0; gnt_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic enq(input int t, input int b, input int r, input bit w);
      @(negedge clk);
      enq_valid = 1'b1; enq_thread = 2'(t); enq_bank = 2'(b);
      enq_row = 12'(r); enq_write = w;
      @(posedge clk); #1;
      enq_valid = 1'b0;
   endtask

   task automatic take(input int exp_row, input string req);
      @(negedge clk); #1;
      check(gnt_valid && gnt_row == 12'(exp_row), req, int'(gnt_row), exp_row);
      gnt_ready = 1'b1;
      @(posedge clk); #1;
      gnt_ready = 1'b0;
   endtask

   task automatic expect_empty(input string req);
      @(negedge clk); #1;
      check(!gnt_valid, req, int'(gnt_valid), 0);
   endtask

   task automatic t_reset_state();
      do_reset();
      @(negedge clk); #1;
      check(!gnt_valid, "R2 reset no grant", int'(gnt_valid), 0);
      check(enq_ready, "R1 reset ready", int'(enq_ready), 1);
   endtask

   task automatic t_fill_full();
      do_reset();
      policy_mode = 2'b00; open_page_mode = 1'b1;
      for (int i = 0; i < 8; i++) begin
         enq(0, i % 4, 70 + i, 1'b0);
         if (i == 6) check(enq_ready, "R1 ready with one slot", int'(enq_ready), 1);
      end
      check(!enq_ready, "R1 full drops ready", int'(enq_ready), 0);
      enq(1, 0, 99, 1'b0);
      for (int i = 0; i < 8; i++) take(70 + i, "R1 drain order");
      expect_empty("R1 dropped request never granted");
   endtask

   task automatic t_same_cycle();
      do_reset();
      policy_mode = 2'b00;
      @(negedge clk);
      enq_valid = 1'b1; enq_thread = 2'd0; enq_bank = 2'd0; enq_row = 12'd60; enq_write = 1'b0;
      gnt_ready = 1'b1;
      #1;
      check(!gnt_valid, "R2 new entry not visible", int'(gnt_valid), 0);
      @(posedge clk); #1;
      enq_valid = 1'b0; gnt_ready = 1'b0;
      @(negedge clk); #1;
      check(gnt_valid && gnt_row == 12'd60, "R2 visible next cycle", int'(gnt_row), 60);
      enq_valid = 1'b1; enq_row = 12'd61; enq_bank = 2'd1; gnt_ready = 1'b1;
      @(posedge clk); #1;
      enq_valid = 1'b0; gnt_ready = 1'b0;
      take(61, "R2 remaining after accept and grant");
      expect_empty("R2 removed on grant");
   endtask

   task automatic t_age_order();
      do_reset();
      policy_mode = 2'b00; open_page_mode = 1'b1;
      enq(1, 0, 5, 1'b0);
      enq(2, 1, 6, 1'b0);
      enq(3, 2, 7, 1'b0);
      take(5, "R8 oldest first");
      take(6, "R8 next oldest");
      take(7, "R8 last");
   endtask

   task automatic t_read_first();
      do_reset();
      policy_mode = 2'b00;
      enq(0, 0, 50, 1'b1);
      enq(0, 1, 51, 1'b0);
      take(51, "R7 read beats older write");
      @(negedge clk); #1;
      check(gnt_write == 1'b1, "R7 write flag", int'(gnt_write), 1);
      take(50, "R7 write later");
   endtask

   task automatic t_row_hit();
      do_reset();
      policy_mode = 2'b00; open_page_mode = 1'b1;
      enq(0, 0, 3, 1'b0);
      take(3, "R9 open row 3 bank 0");
      enq(0, 2, 1, 1'b0);
      enq(0, 0, 9, 1'b0);
      enq(0, 0, 3, 1'b1);
      take(3, "R6 hit beats older reads");
      take(1, "R8 older miss next");
      take(9, "R8 last miss");
      enq(0, 0, 40, 1'b0);
      take(40, "R9 reopen bank 0 at row 40");
      enq(0, 1, 40, 1'b0);
      enq(0, 0, 40, 1'b0);
      @(negedge clk); #1;
      check(gnt_bank == 2'd0, "R9 hit only in own bank", int'(gnt_bank), 0);
      take(40, "R9 drain");
      take(40, "R9 drain");
   endtask

   task automatic t_close_page();
      do_reset();
      policy_mode = 2'b00; open_page_mode = 1'b0;
      enq(0, 0, 3, 1'b0);
      take(3, "R10 first access");
      enq(0, 0, 9, 1'b0);
      enq(0, 0, 3, 1'b0);
      take(9, "R10 no hit, age decides");
      take(3, "R10 drain");
      open_page_mode = 1'b1;
   endtask

   task automatic t_pending();
      do_reset();
      policy_mode = 2'b01; open_page_mode = 1'b1;
      enq(0, 0, 10, 1'b0);
      enq(0, 1, 11, 1'b0);
      enq(1, 2, 12, 1'b0);
      take(12, "R3 fewer pending wins");
      @(negedge clk); #1;
      check(gnt_row == 12'd10, "R3 thread 0 oldest", int'(gnt_row), 10);
      enq_valid = 1'b1; enq_thread = 2'd1; enq_bank = 2'd3; enq_row = 12'd13; enq_write = 1'b0;
      gnt_ready = 1'b1;
      @(posedge clk); #1;
      enq_valid = 1'b0; gnt_ready = 1'b0;
      take(11, "R11 counter decrement makes a tie");
      take(13, "R11 last");
      policy_mode = 2'b00;
   endtask

   task automatic t_occupancy();
      do_reset();
      policy_mode = 2'b10;
      occ_count = '0;
      occ_count[0*OW +: OW] = 8'd5;
      occ_count[1*OW +: OW] = 8'd20;
      enq(0, 0, 20, 1'b0);
      enq(1, 1, 21, 1'b1);
      @(negedge clk); #1;
      check(gnt_row == 12'd21, "R4 larger occupancy wins", int'(gnt_row), 21);
      occ_count[0*OW +: OW] = 8'd30;
      #1;
      check(gnt_row == 12'd20, "R4 follows occupancy change", int'(gnt_row), 20);
      take(20, "R4 drain");
      take(21, "R4 drain");
   endtask

   task automatic t_plain_ignores_thread();
      do_reset();
      policy_mode = 2'b00;
      occ_count[0*OW +: OW] = 8'd1;
      occ_count[1*OW +: OW] = 8'd200;
      enq(0, 0, 30, 1'b0);
      enq(0, 1, 31, 1'b0);
      enq(1, 2, 32, 1'b0);
      take(30, "R5 plain age order");
      take(31, "R5 plain age order");
      take(32, "R5 plain age order");
      policy_mode = 2'b11;
      enq(0, 0, 33, 1'b0);
      enq(1, 1, 34, 1'b0);
      take(33, "R5 spare code is plain");
      take(34, "R5 drain");
      policy_mode = 2'b00;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 50000) begin
            check(1'b0, "watchdog", cycles, 50000);
            finish_run();
         end
      end
   end

   initial begin
      t_reset_state();
      t_fill_full();
      t_same_cycle();
      t_age_order();
      t_read_first();
      t_row_hit();
      t_close_page();
      t_pending();
      t_occupancy();
      t_plain_ignores_thread();
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule